// File: doc/BRIEF.md
# Two-Wire Bus Target Address Detector

This block listens to a two-wire serial bus (SCL clock line, SDA data line) from the fast system clock domain. It first synchronises both lines. It then recognises the bus framing conditions and, after every START, collects the address byte that the controller sends. From that byte it decides whether this target answers. When it answers, it pulls SDA low through an open-drain enable for the whole acknowledge clock.

Software sets three inputs: the 7-bit address of this target, a switch that lets it answer the broadcast (general call) address, and a busy flag that forces a refusal. Downstream logic gets single-cycle pulses for an accepted read, an accepted write and an accepted broadcast. It also gets the direction bit of the last completed address byte and a pulse for each START and STOP condition. Everything after the acknowledge clock is handled elsewhere.

Top module: `i2c_addr_snoop`

## Requirements
- R1: `start_pulse` is high for one cycle after SDA falls while SCL is high. `stop_pulse` is high for one cycle after SDA rises while SCL is high.
- R2: The eight bits after a START are sampled on rising SCL edges, most significant first. The first seven are the address and the eighth is the direction bit, where 1 means read and 0 means write. `rw_bit` takes the eighth bit once the falling SCL edge after that bit arrives, whatever the decision.
- R3: When the address equals `own_addr` (and is neither 0000000 nor of the form 1111xxx), `sda_pull_low` is set after the falling SCL edge that ends bit 8. It is cleared after the falling edge that ends bit 9. In the same cycle that the pull starts, `rd_hit` pulses for a read or `wr_hit` pulses for a write.
- R4: A non-matching address leaves `sda_pull_low` low and gives no hit pulse.
- R5: Address 0000000 with direction write is acknowledged, with a `gc_hit` pulse, only when `gc_enable` is 1. With `gc_enable` at 0 it gets no acknowledge.
- R6: Address 0000000 with direction read is never acknowledged and gives no pulse.
- R7: Addresses 1111xxx are never acknowledged, even when `own_addr` holds the same value.
- R8: While `busy` is 1 at the decision, no address is acknowledged and no hit pulse is given.
- R9: A STOP aborts any capture in progress. SCL clocking after that, without a new START, never sets `sda_pull_low`.
- R10: A repeated START in the middle of a byte restarts the bit count from zero without giving a `stop_pulse`. The byte that follows is judged on its own.
- R11: After reset, `sda_pull_low`, all hit pulses, `start_pulse`, `stop_pulse` and `rw_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| own_addr | input | 7 | Address this target answers to |
| gc_enable | input | 1 | Allow acknowledge of general call write |
| busy | input | 1 | Refuse every address while set |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| rd_hit | output | 1 | One-cycle pulse: own address, read, acknowledged |
| wr_hit | output | 1 | One-cycle pulse: own address, write, acknowledged |
| gc_hit | output | 1 | One-cycle pulse: general call write acknowledged |
| rw_bit | output | 1 | Direction bit of the last completed address byte |
| start_pulse | output | 1 | One-cycle pulse per START or repeated START |
| stop_pulse | output | 1 | One-cycle pulse per STOP |

## Verification
Framing detection and bit capture compete for the same state update: a START or STOP can arrive while the shifter is partway through a byte. The bench provokes this by breaking off a byte after four bits with a repeated START, and another after three bits with a STOP. For the repeated START, the checks are that no stop pulse appears and that the next full byte is acknowledged correctly. For the STOP, the check is that later clocking never pulls SDA. A NACK followed straight away by a repeated START to the own address shows that a refused decision hands control back to framing detection.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_SHIFT = 2'd1,
    CAP_ACK   = 2'd2
  } cap_state_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic gc;
  } addr_hit_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/bus_cond_det.sv
module bus_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_c,
  output logic stop_c,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Data edges only count as framing while the clock stays high on both samples.
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
endmodule

// File: rtl/addr_capture.sv
module addr_capture
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_c,
  input  logic              stop_c,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_enable,
  input  logic              busy,
  output logic              sda_pull_low,
  output addr_hit_t         hit,
  output logic              rw_bit,
  output logic              start_pulse,
  output logic              stop_pulse
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int RSV_W  = 4;

  cap_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shreg;

  logic [ADDR_W-1:0] rx_addr;
  logic              rx_rw, is_gc, is_rsv, own_match, accept;
  addr_hit_t         next_hit;

  always_comb begin
    rx_addr   = shreg[BYTE_W-1:1];
    rx_rw     = shreg[0];
    is_gc     = (rx_addr == '0);
    is_rsv    = (rx_addr[ADDR_W-1 -: RSV_W] == '1);
    own_match = (rx_addr == own_addr) && !is_gc && !is_rsv;
    accept    = !busy && (own_match || (is_gc && gc_enable && !rx_rw));
    next_hit.rd = accept && own_match && rx_rw;
    next_hit.wr = accept && own_match && !rx_rw;
    next_hit.gc = accept && is_gc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= CAP_IDLE;
      bit_cnt      <= '0;
      shreg        <= '0;
      sda_pull_low <= 1'b0;
      hit          <= '0;
      rw_bit       <= 1'b0;
      start_pulse  <= 1'b0;
      stop_pulse   <= 1'b0;
    end else begin
      start_pulse <= start_c;
      stop_pulse  <= stop_c;
      hit         <= '0;
      if (start_c) begin
        state        <= CAP_SHIFT;
        bit_cnt      <= '0;
        sda_pull_low <= 1'b0;
      end else if (stop_c) begin
        state        <= CAP_IDLE;
        bit_cnt      <= '0;
        sda_pull_low <= 1'b0;
      end else begin
        case (state)
          CAP_SHIFT: begin
            if (scl_rise && (bit_cnt < CNT_W'(BYTE_W))) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && (bit_cnt == CNT_W'(BYTE_W))) begin
              rw_bit <= rx_rw;
              hit    <= next_hit;
              if (accept) begin
                sda_pull_low <= 1'b1;
                state        <= CAP_ACK;
              end else begin
                state <= CAP_IDLE;
              end
            end
          end
          CAP_ACK: begin
            if (scl_fall) begin
              sda_pull_low <= 1'b0;
              state        <= CAP_IDLE;
            end
          end
          default: state <= CAP_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_snoop.sv
module i2c_addr_snoop
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_enable,
  input  logic              busy,
  output logic              sda_pull_low,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              gc_hit,
  output logic              rw_bit,
  output logic              start_pulse,
  output logic              stop_pulse
);
  logic [1:0] line_s;
  logic       start_c, stop_c, scl_rise, scl_fall;
  addr_hit_t  hit;

  bus_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_in, sda_in}),
    .dout (line_s)
  );

  bus_cond_det u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (line_s[1]),
    .sda_s    (line_s[0]),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  addr_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk          (clk),
    .rst          (rst),
    .start_c      (start_c),
    .stop_c       (stop_c),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .sda_s        (line_s[0]),
    .own_addr     (own_addr),
    .gc_enable    (gc_enable),
    .busy         (busy),
    .sda_pull_low (sda_pull_low),
    .hit          (hit),
    .rw_bit       (rw_bit),
    .start_pulse  (start_pulse),
    .stop_pulse   (stop_pulse)
  );

  assign rd_hit = hit.rd;
  assign wr_hit = hit.wr;
  assign gc_hit = hit.gc;
endmodule

// File: rtl/i2c_addr_snoop_chk.sv
module i2c_addr_snoop_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic sda_pull_low,
  input logic rd_hit,
  input logic wr_hit,
  input logic gc_hit,
  input logic rw_bit,
  input logic start_pulse,
  input logic stop_pulse
);
  a_r1_start_stop_apart: assert property (@(posedge clk) disable iff (rst)
    !(start_pulse && stop_pulse));

  a_r1_stop_frees_line: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !sda_pull_low);

  a_r3_pull_needs_hit: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> (rd_hit || wr_hit || gc_hit));

  a_r3_hits_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_hit, wr_hit, gc_hit}));

  a_r3_read_dir: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> rw_bit);

  a_r3_write_dir: assert property (@(posedge clk) disable iff (rst)
    wr_hit |-> !rw_bit);

  a_r6_gc_is_write: assert property (@(posedge clk) disable iff (rst)
    gc_hit |-> !rw_bit);

  a_r8_busy_refuses: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> !$past(busy));
endmodule

bind i2c_addr_snoop i2c_addr_snoop_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .sda_pull_low (sda_pull_low),
  .rd_hit       (rd_hit),
  .wr_hit       (wr_hit),
  .gc_hit       (gc_hit),
  .rw_bit       (rw_bit),
  .start_pulse  (start_pulse),
  .stop_pulse   (stop_pulse)
);

// File: tb/sim_i2c_addr_snoop.sv
module sim_i2c_addr_snoop;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [6:0] own_addr = 7'h2A;
  logic       gc_enable = 1'b0;
  logic       busy = 1'b0;
  logic       sda_pull_low, rd_hit, wr_hit, gc_hit, rw_bit, start_pulse, stop_pulse;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  int n_rd, n_wr, n_gc, n_start, n_stop, n_pull;
  logic ack_seen, released;
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_bus = m_sda & ~sda_pull_low;

  i2c_addr_snoop u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
    .own_addr(own_addr), .gc_enable(gc_enable), .busy(busy),
    .sda_pull_low(sda_pull_low), .rd_hit(rd_hit), .wr_hit(wr_hit),
    .gc_hit(gc_hit), .rw_bit(rw_bit), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse)
  );

  always @(negedge clk) begin
    if (rd_hit) n_rd++;
    if (wr_hit) n_wr++;
    if (gc_hit) n_gc++;
    if (start_pulse) n_start++;
    if (stop_pulse) n_stop++;
    if (sda_pull_low) n_pull++;
  end

  typedef struct packed {
    logic [6:0] own;
    logic       gce;
    logic       bsy;
    logic [7:0] byte_v;
    logic       e_ack;
    logic       e_rd;
    logic       e_wr;
    logic       e_gc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{7'h2A, 1'b0, 1'b0, 8'h54, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 write match
    '{7'h2A, 1'b0, 1'b0, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 read match
    '{7'h2A, 1'b0, 1'b0, 8'h56, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 other address
    '{7'h2A, 1'b0, 1'b0, 8'hD4, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 MSB differs
    '{7'h2A, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 gc write enabled
    '{7'h2A, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 gc write disabled
    '{7'h2A, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 gc read
    '{7'h7A, 1'b1, 1'b0, 8'hF4, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 reserved
    '{7'h2A, 1'b1, 1'b1, 8'h54, 1'b0, 1'b0, 1'b0, 1'b0}  // R8 busy
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_counts();
    n_rd = 0; n_wr = 0; n_gc = 0; n_start = 0; n_stop = 0; n_pull = 0;
  endtask

  task automatic do_start();
    m_sda = 1'b1; wclk(10); scl = 1'b1; wclk(10);
    m_sda = 1'b0; wclk(10); scl = 1'b0; wclk(10);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wclk(10); scl = 1'b1; wclk(10);
    m_sda = 1'b1; wclk(10);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wclk(10); scl = 1'b1; wclk(10); scl = 1'b0; wclk(10);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic ack_slot();
    m_sda = 1'b1; wclk(10); scl = 1'b1; wclk(5);
    ack_seen = sda_pull_low;
    wclk(5); scl = 1'b0; wclk(10);
    released = ~sda_pull_low;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_counts();
    wclk(5);
    // R11 reset state
    chk("R11 pull", sda_pull_low, 0);
    chk("R11 hits", rd_hit | wr_hit | gc_hit, 0);
    chk("R11 rw", rw_bit, 0);
    chk("R11 framing", start_pulse | stop_pulse, 0);
    rst = 1'b0;
    wclk(10);

    for (int v = 0; v < NV; v++) begin
      own_addr = VECS[v].own; gc_enable = VECS[v].gce; busy = VECS[v].bsy;
      clr_counts();
      do_start();
      chk("R1 start pulse", n_start, 1);
      send_byte(VECS[v].byte_v);
      ack_slot();
      do_stop();
      chk($sformatf("R3 ack v%0d", v), ack_seen, VECS[v].e_ack);
      chk($sformatf("R3 release v%0d", v), released, 1);
      chk($sformatf("R3 rd v%0d", v), n_rd, VECS[v].e_rd);
      chk($sformatf("R3 wr v%0d", v), n_wr, VECS[v].e_wr);
      chk($sformatf("R5 gc v%0d", v), n_gc, VECS[v].e_gc);
      chk($sformatf("R2 rw v%0d", v), rw_bit, VECS[v].byte_v[0]);
      chk("R1 stop pulse", n_stop, 1);
    end

    own_addr = 7'h2A; gc_enable = 1'b0; busy = 1'b0;

    // R10 repeated START after four bits
    clr_counts();
    do_start();
    send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    do_start();
    chk("R10 two starts", n_start, 2);
    chk("R10 no stop", n_stop, 0);
    send_byte(8'h55);
    ack_slot();
    chk("R10 ack after restart", ack_seen, 1);
    chk("R10 read hit", n_rd, 1);
    do_stop();

    // R9 STOP after three bits, then clocking without START
    clr_counts();
    do_start();
    send_bit(0); send_bit(1); send_bit(0);
    do_stop();
    m_sda = 1'b1; wclk(10); scl = 1'b0; wclk(10);
    send_byte(8'h54);
    ack_slot();
    chk("R9 no pull after stop", n_pull, 0);
    chk("R9 no hit", n_wr + n_rd + n_gc, 0);
    m_sda = 1'b0; wclk(10); do_stop();

    // R4 then R10: NACK followed by repeated START to own address
    clr_counts();
    do_start();
    send_byte(8'h10);
    ack_slot();
    chk("R4 nack", ack_seen, 0);
    do_start();
    chk("R10 no stop after nack", n_stop, 0);
    send_byte(8'h54);
    ack_slot();
    chk("R10 ack after nack", ack_seen, 1);
    chk("R3 write hit", n_wr, 1);
    do_stop();

    // R7 reserved address with own address on same value, write
    own_addr = 7'h78; clr_counts();
    do_start(); send_byte(8'hF0); ack_slot(); do_stop();
    chk("R7 reserved write", n_pull, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule